// File: doc/BRIEF.md
# Bus Takeover DMA Sequencer for an Expansion Card

This block lets an expansion card become the master of a synchronous 8-bit system bus whose processor can be halted and floated. Software arms it through a small register window that holds a start address, a byte count, a direction and an execute flag. Once armed, the block waits for a moment when the bus is free. It then halts the processor and floats its outputs by pulling the ready and bus-enable lines low in the same cycle. It marks the bus as busy by pulling the shared active-low lock line. Next it moves one byte per bus clock between system memory and a local buffer port. Finally it hands the bus back in a fixed order and raises an interrupt.

A bus cycle happens on every clock, so the block never leaves a cycle undefined while it owns the bus. The cycle in which it takes the bus is a harmless read of a parking address. When it gives the bus back, it first stops driving address and data. It then drops the lock, and only after that does it release ready and bus enable. There is an optional mode for taking the bus only on opcode-fetch cycles, and in that mode the lock line is not consulted. A chip reset clears all state at once and releases every line, including in the middle of a transfer.

Top module: `card_bus_takeover`

## Requirements
- R1: While reset is asserted and after it is released, `rdy_pull`, `be_pull`, `lock_pull`, `bus_addr_oe`, `bus_data_oe` and `irq` are 0, and every register reads 0.
- R2: The block never pulls a bus line unless the execute flag (control bit 0) is 1. Writing control with bit 0 = 0 starts nothing.
- R3: In normal mode, the bus is taken only after a clock edge at which `rdy_in`, `be_in` and `lock_n_in` were all sampled high. Otherwise the block keeps waiting. `rdy_pull`, `be_pull` and `lock_pull` rise in the same cycle.
- R4: With control bit 2 = 1 (fetch-only mode), the sampled condition is `rdy_in`, `be_in` and `sync_in` all high, and the level of `lock_n_in` does not matter.
- R5: The first owned cycle drives a read (`bus_rwb` = 1) of PARK_ADDR (default FFFF hex). The next LEN cycles drive addresses START, START+1, and so on, one per clock, with all three pulls held.
- R6: With control bit 1 = 0, every transfer cycle is a read: `bus_rwb` = 1, and `bus_din` is written to buffer index i. With bit 1 = 1, every transfer cycle is a write: `bus_rwb` = 0, `bus_data_oe` = 1 and `bus_dout` = buffer[i].
- R7: After the last byte, the block runs one cycle with address and data undriven while all pulls stay held. Then it runs one cycle with only `lock_pull` released. Then it releases `rdy_pull` and `be_pull` together.
- R8: Completion sets the done bit (status bit 1) and `irq`, and clears the execute flag and busy (status bit 0). Writing status with bit 1 = 1 clears done, and writing 0 there does not. If completion and a clear fall in the same cycle, done ends set.
- R9: Starting with a length of 0 sets done without pulling any bus line.
- R10: While busy, host writes to offsets 0 to 4 are ignored.
- R11: An asynchronous reset during a transfer releases every pull and output enable immediately and returns all registers to 0.
- R12: The register offsets are: 0 control, 1 address low, 2 address high, 3 length low, 4 length high, 5 status. Offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_sel | input | 3 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Register read data for host_sel |
| irq | output | 1 | Interrupt request, high while done is set |
| rdy_in | input | 1 | Sampled level of the ready line |
| be_in | input | 1 | Sampled level of the bus-enable line |
| lock_n_in | input | 1 | Sampled level of the active-low lock line |
| sync_in | input | 1 | Opcode-fetch indicator |
| rdy_pull | output | 1 | Pull the ready line low |
| be_pull | output | 1 | Pull the bus-enable line low |
| lock_pull | output | 1 | Pull the lock line low |
| bus_addr | output | 16 | Address driven while owning the bus |
| bus_addr_oe | output | 1 | Address and read/write output enable |
| bus_rwb | output | 1 | 1 = read, 0 = write |
| bus_din | input | 8 | System data bus in |
| bus_dout | output | 8 | System data bus out |
| bus_data_oe | output | 1 | Data output enable |
| buf_addr | output | 8 | Local buffer index |
| buf_we | output | 1 | Local buffer write enable |
| buf_wdata | output | 8 | Local buffer write data |
| buf_rdata | input | 8 | Local buffer read data, combinational from buf_addr |

## Verification
Two things can land on the same clock edge: the completion of a transfer, which sets done, and a host write that clears done. The bench issues the clearing write so that it takes effect at the edge that ends the lock-release cycle. It then expects `irq` still high and status reading done, while transfers without this collision end with done cleared by a later write. A second overlap, a host write to the descriptor while the block is waiting for a safe point, is provoked by holding a bus line low. The bench judges it by reading the register back and by the addresses the transfer later drives.

// File: rtl/card_bus_pkg.sv
`timescale 1ns/1ps
package card_bus_pkg;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] OFS_CTRL   = 3'd0;
  localparam logic [SEL_W-1:0] OFS_ADR_LO = 3'd1;
  localparam logic [SEL_W-1:0] OFS_ADR_HI = 3'd2;
  localparam logic [SEL_W-1:0] OFS_LEN_LO = 3'd3;
  localparam logic [SEL_W-1:0] OFS_LEN_HI = 3'd4;
  localparam logic [SEL_W-1:0] OFS_STAT   = 3'd5;

  localparam int CTRL_GO   = 0;
  localparam int CTRL_DIR  = 1;
  localparam int CTRL_SYNC = 2;
  localparam int STAT_BUSY = 0;
  localparam int STAT_DONE = 1;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WAIT   = 3'd1,
    ST_GRAB   = 3'd2,
    ST_MOVE   = 3'd3,
    ST_FLOAT  = 3'd4,
    ST_UNLOCK = 3'd5
  } bus_state_e;
endpackage

// File: rtl/card_bus_regs.sv
`timescale 1ns/1ps
module card_bus_regs
  import card_bus_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [SEL_W-1:0]  host_sel,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  input  logic              fin,
  output logic              go,
  output logic              dir,
  output logic              sync_only,
  output logic [ADDR_W-1:0] start_addr,
  output logic [LEN_W-1:0]  xfer_len,
  output logic              done
);
  localparam int WIDE = 2 * DW;

  logic              go_q, go_d, dir_q, dir_d, syn_q, syn_d, done_q, done_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              wr_ok, clr_done, reg_en;
  logic [WIDE-1:0]   addr_x, len_x;

  always_comb begin
    wr_ok    = host_wr && !go_q;
    clr_done = host_wr && (host_sel == OFS_STAT) && host_wdata[STAT_DONE];
    reg_en   = wr_ok || clr_done || fin;
    go_d   = go_q;
    dir_d  = dir_q;
    syn_d  = syn_q;
    addr_d = addr_q;
    len_d  = len_q;
    done_d = done_q;
    if (wr_ok) begin
      case (host_sel)
        OFS_CTRL: begin
          go_d  = host_wdata[CTRL_GO];
          dir_d = host_wdata[CTRL_DIR];
          syn_d = host_wdata[CTRL_SYNC];
        end
        OFS_ADR_LO: addr_d[DW-1:0]      = host_wdata;
        OFS_ADR_HI: addr_d[ADDR_W-1:DW] = host_wdata[ADDR_W-DW-1:0];
        OFS_LEN_LO: len_d[DW-1:0]       = host_wdata;
        OFS_LEN_HI: len_d[LEN_W-1:DW]   = host_wdata[LEN_W-DW-1:0];
        default: ;
      endcase
    end
    if (clr_done) done_d = 1'b0;
    if (fin) begin
      go_d   = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q   <= 1'b0;
      dir_q  <= 1'b0;
      syn_q  <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
    end else if (reg_en) begin
      go_q   <= go_d;
      dir_q  <= dir_d;
      syn_q  <= syn_d;
      done_q <= done_d;
      addr_q <= addr_d;
      len_q  <= len_d;
    end
  end

  assign addr_x = WIDE'(addr_q);
  assign len_x  = WIDE'(len_q);

  always_comb begin
    host_rdata = '0;
    case (host_sel)
      OFS_CTRL: begin
        host_rdata[CTRL_GO]   = go_q;
        host_rdata[CTRL_DIR]  = dir_q;
        host_rdata[CTRL_SYNC] = syn_q;
      end
      OFS_ADR_LO: host_rdata = addr_x[DW-1:0];
      OFS_ADR_HI: host_rdata = addr_x[WIDE-1:DW];
      OFS_LEN_LO: host_rdata = len_x[DW-1:0];
      OFS_LEN_HI: host_rdata = len_x[WIDE-1:DW];
      OFS_STAT: begin
        host_rdata[STAT_BUSY] = go_q;
        host_rdata[STAT_DONE] = done_q;
      end
      default: host_rdata = '0;
    endcase
  end

  assign go         = go_q;
  assign dir        = dir_q;
  assign sync_only  = syn_q;
  assign start_addr = addr_q;
  assign xfer_len   = len_q;
  assign done       = done_q;
endmodule

// File: rtl/card_bus_seq.sv
`timescale 1ns/1ps
module card_bus_seq
  import card_bus_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             sync_only,
  input  logic             rdy_in,
  input  logic             be_in,
  input  logic             lock_n_in,
  input  logic             sync_in,
  input  logic             last,
  output bus_state_e       state,
  output logic             fin
);
  bus_state_e st_q, st_d;
  logic       safe, len_zero;

  always_comb begin
    len_zero = (xfer_len == '0);
    safe     = rdy_in && be_in && (sync_only ? sync_in : lock_n_in);
    st_d     = st_q;
    fin      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (go) begin
          if (len_zero) fin  = 1'b1;
          else          st_d = ST_WAIT;
        end
      end
      ST_WAIT:  if (safe) st_d = ST_GRAB;
      ST_GRAB:  st_d = ST_MOVE;
      ST_MOVE:  if (last) st_d = ST_FLOAT;
      ST_FLOAT: st_d = ST_UNLOCK;
      ST_UNLOCK: begin
        st_d = ST_IDLE;
        fin  = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
endmodule

// File: rtl/card_bus_beat.sv
`timescale 1ns/1ps
module card_bus_beat
  import card_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_state_e        state,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic [LEN_W-1:0]  idx,
  output logic              last,
  output logic [ADDR_W-1:0] beat_addr
);
  logic [LEN_W-1:0] idx_q, idx_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (state == ST_GRAB) || (state == ST_MOVE);
    idx_d  = (state == ST_GRAB) ? '0 : idx_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (cnt_en) idx_q <= idx_d;
  end

  assign idx       = idx_q;
  assign last      = (idx_q == xfer_len - LEN_W'(1));
  assign beat_addr = start_addr + ADDR_W'(idx_q);
endmodule

// File: rtl/card_bus_takeover.sv
`timescale 1ns/1ps
module card_bus_takeover
  import card_bus_pkg::*;
#(
  parameter int               DW        = 8,
  parameter int               ADDR_W    = 16,
  parameter int               LEN_W     = 16,
  parameter int               BUF_AW    = 8,
  parameter logic [ADDR_W-1:0] PARK_ADDR = {ADDR_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [2:0]        host_sel,
  input  logic [DW-1:0]     host_wdata,
  output logic [DW-1:0]     host_rdata,
  output logic              irq,
  input  logic              rdy_in,
  input  logic              be_in,
  input  logic              lock_n_in,
  input  logic              sync_in,
  output logic              rdy_pull,
  output logic              be_pull,
  output logic              lock_pull,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_addr_oe,
  output logic              bus_rwb,
  input  logic [DW-1:0]     bus_din,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_data_oe,
  output logic [BUF_AW-1:0] buf_addr,
  output logic              buf_we,
  output logic [DW-1:0]     buf_wdata,
  input  logic [DW-1:0]     buf_rdata
);
  logic [1:0]        rs_q;
  logic              rst_core_n;
  logic              go, dir, cfg_sync, done, fin, last, moving;
  logic [ADDR_W-1:0] start_addr, beat_addr;
  logic [LEN_W-1:0]  xfer_len, idx;
  bus_state_e        state;

  // reset: asserted at once, released two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  card_bus_regs #(.DW(DW), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .fin        (fin),
    .go         (go),
    .dir        (dir),
    .sync_only  (cfg_sync),
    .start_addr (start_addr),
    .xfer_len   (xfer_len),
    .done       (done)
  );

  card_bus_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .go        (go),
    .xfer_len  (xfer_len),
    .sync_only (cfg_sync),
    .rdy_in    (rdy_in),
    .be_in     (be_in),
    .lock_n_in (lock_n_in),
    .sync_in   (sync_in),
    .last      (last),
    .state     (state),
    .fin       (fin)
  );

  card_bus_beat #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_beat (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .state      (state),
    .start_addr (start_addr),
    .xfer_len   (xfer_len),
    .idx        (idx),
    .last       (last),
    .beat_addr  (beat_addr)
  );

  always_comb begin
    moving      = (state == ST_MOVE);
    rdy_pull    = state inside {ST_GRAB, ST_MOVE, ST_FLOAT, ST_UNLOCK};
    be_pull     = rdy_pull;
    lock_pull   = state inside {ST_GRAB, ST_MOVE, ST_FLOAT};
    bus_addr_oe = (state == ST_GRAB) || moving;
    bus_addr    = moving ? beat_addr : PARK_ADDR;
    bus_rwb     = !(moving && dir);
    bus_data_oe = moving && dir;
    bus_dout    = bus_data_oe ? buf_rdata : '0;
    buf_we      = moving && !dir;
    buf_wdata   = bus_din;
    buf_addr    = idx[BUF_AW-1:0];
    irq         = done;
  end
endmodule

// File: rtl/card_bus_chk.sv
`timescale 1ns/1ps
module card_bus_chk (
  input logic clk,
  input logic rst_n,
  input logic rdy_in,
  input logic be_in,
  input logic lock_n_in,
  input logic sync_in,
  input logic sync_only,
  input logic rdy_pull,
  input logic be_pull,
  input logic lock_pull,
  input logic bus_addr_oe,
  input logic bus_data_oe,
  input logic bus_rwb,
  input logic irq
);
  // R3 and R4: the bus is taken only after a safe sample
  a_r3_grab_when_safe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_pull) |-> $past(rdy_in && be_in && (sync_only ? sync_in : lock_n_in)));

  // R3: all three lines are pulled together
  a_r3_pull_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_pull) |-> (be_pull && lock_pull));

  // R5: address is driven only while the processor is halted and floated
  a_r5_drive_owned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_oe |-> (rdy_pull && be_pull && lock_pull));

  // R6: data is driven only in write cycles
  a_r6_data_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    bus_data_oe |-> !bus_rwb);

  // R7: outputs float before the lock drops, and ready/enable are still held
  a_r7_float_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_pull) |-> (rdy_pull && be_pull && !$past(bus_addr_oe) && !$past(bus_data_oe)));

  // R7: the lock is released before ready and enable
  a_r7_unlock_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_pull) |-> ($past(!lock_pull) && !be_pull));

  // R8: the interrupt rises only once the bus is handed back
  a_r8_irq_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (!rdy_pull && !lock_pull));
endmodule

bind card_bus_takeover card_bus_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rdy_in      (rdy_in),
  .be_in       (be_in),
  .lock_n_in   (lock_n_in),
  .sync_in     (sync_in),
  .sync_only   (cfg_sync),
  .rdy_pull    (rdy_pull),
  .be_pull     (be_pull),
  .lock_pull   (lock_pull),
  .bus_addr_oe (bus_addr_oe),
  .bus_data_oe (bus_data_oe),
  .bus_rwb     (bus_rwb),
  .irq         (irq)
);

// File: tb/test_card_bus_takeover.sv
`timescale 1ns/1ps
module test_card_bus_takeover;
  localparam int CLK_NS = 8;

  logic clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [2:0]  host_sel = 3'd0;
  logic [7:0]  host_wdata = 8'd0;
  logic [7:0]  host_rdata;
  logic        irq;
  logic        rdy_o = 1'b1, be_o = 1'b1, lock_o = 1'b1;
  logic        sync_in = 1'b0;
  logic        rdy_in, be_in, lock_n_in;
  logic        rdy_pull, be_pull, lock_pull;
  logic [15:0] bus_addr;
  logic        bus_addr_oe, bus_rwb, bus_data_oe;
  logic [7:0]  bus_din, bus_dout;
  logic [7:0]  buf_addr, buf_wdata, buf_rdata;
  logic        buf_we;
  logic [7:0]  bufm [256];

  int checks = 0;
  int errs   = 0;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign rdy_in    = rdy_o & ~rdy_pull;
  assign be_in     = be_o & ~be_pull;
  assign lock_n_in = lock_o & ~lock_pull;
  assign bus_din   = memf(bus_addr);
  assign buf_rdata = bufm[buf_addr];

  always @(posedge clk) if (buf_we) bufm[buf_addr] <= buf_wdata;

  card_bus_takeover i_card_bus_takeover (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .rdy_in(rdy_in), .be_in(be_in), .lock_n_in(lock_n_in), .sync_in(sync_in),
    .rdy_pull(rdy_pull), .be_pull(be_pull), .lock_pull(lock_pull),
    .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe), .bus_rwb(bus_rwb),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_data_oe(bus_data_oe),
    .buf_addr(buf_addr), .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic hw(input logic [2:0] sel, input logic [7:0] data);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = data;
    @(posedge clk);
    #1 host_wr = 1'b0;
  endtask

  task automatic hr(input logic [2:0] sel, output logic [7:0] data);
    @(negedge clk);
    host_sel = sel;
    #1 data = host_rdata;
  endtask

  function automatic logic [31:0] pins();
    return 32'({rdy_pull, be_pull, lock_pull, bus_addr_oe, bus_data_oe});
  endfunction

  task automatic run_xfer(input logic [15:0] start, input logic [15:0] len,
                          input logic dir, input logic smode, input int hold,
                          input int kind, input logic clash, input logic poke);
    logic [7:0] rd;
    bit seen;
    int k;
    for (int i = 0; i < int'(len); i++)
      bufm[i] = dir ? 8'($urandom) : ~memf(start + 16'(i));
    hw(3'd1, start[7:0]); hw(3'd2, start[15:8]);
    hw(3'd3, len[7:0]);   hw(3'd4, len[15:8]);
    if (smode) begin
      lock_o  = 1'b0;
      sync_in = (hold == 0);
    end else if (hold > 0) begin
      case (kind % 3)
        0: rdy_o = 1'b0;
        1: be_o = 1'b0;
        default: lock_o = 1'b0;
      endcase
    end
    hw(3'd0, {5'd0, smode, dir, 1'b1});
    if (poke && hold > 0) begin
      hw(3'd1, start[7:0] ^ 8'hFF);
      hr(3'd1, rd);
      chk("R10", "address low written while busy", 32'(rd), 32'(start[7:0]));
    end
    for (int j = 0; j < hold; j++) begin
      @(negedge clk);
      chk(smode ? "R4" : "R3", "no takeover while unsafe", pins(), 32'd0);
    end
    rdy_o = 1'b1; be_o = 1'b1;
    if (smode) sync_in = 1'b1; else lock_o = 1'b1;
    seen = 0; k = 0;
    while (!seen && k < 6) begin
      @(negedge clk);
      if (rdy_pull) seen = 1;
      k++;
    end
    chk(smode ? "R4" : "R3", "bus acquired", 32'(seen), 32'd1);
    chk("R3", "pulls rise together", 32'({rdy_pull, be_pull, lock_pull}), 32'h7);
    chk("R5", "parking read", 32'({bus_addr_oe, bus_rwb, bus_data_oe, bus_addr}),
        32'({1'b1, 1'b1, 1'b0, 16'hFFFF}));
    for (int i = 0; i < int'(len); i++) begin
      @(negedge clk);
      chk("R5", "beat address", 32'({bus_addr_oe, rdy_pull, be_pull, lock_pull, bus_addr}),
          32'({4'hF, start + 16'(i)}));
      chk("R6", "beat direction", 32'({bus_rwb, bus_data_oe, buf_we}), 32'({~dir, dir, ~dir}));
      if (dir) chk("R6", "write data", 32'(bus_dout), 32'(bufm[i]));
    end
    @(negedge clk);
    chk("R7", "float cycle", pins(), 32'b11100);
    @(negedge clk);
    chk("R7", "unlock cycle", pins(), 32'b11000);
    if (clash) begin
      host_sel = 3'd5; host_wdata = 8'h02; host_wr = 1'b1;
      @(posedge clk);
      #1 host_wr = 1'b0;
    end
    @(negedge clk);
    chk("R7", "released", pins(), 32'd0);
    chk("R8", clash ? "done wins over same-cycle clear" : "irq after release", 32'(irq), 32'd1);
    hr(3'd5, rd);
    chk("R8", "status done not busy", 32'(rd), 32'h2);
    hr(3'd0, rd);
    chk("R8", "execute flag cleared", 32'(rd), 32'({smode, dir, 1'b0}));
    if (!dir)
      for (int i = 0; i < int'(len); i++)
        chk("R6", "read byte landed in buffer", 32'(bufm[i]), 32'(memf(start + 16'(i))));
    hw(3'd5, 8'h02);
    chk("R8", "clear by writing 1", 32'(irq), 32'd0);
    lock_o = 1'b1; sync_in = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
  endtask

  initial begin
    #(CLK_NS * 150000);
    checks++; errs++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    bit any;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) bufm[i] = 8'd0;

    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "pins in reset", {pins()[31:1], irq}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "pins after reset", {pins()[31:1], irq}, 32'd0);
    for (int s = 0; s < 6; s++) begin
      hr(3'(s), rd);
      chk("R1", "register after reset", 32'(rd), 32'd0);
    end

    // R12 unused offsets and readback
    hw(3'd1, 8'hA5); hw(3'd4, 8'h3C);
    hr(3'd1, rd); chk("R12", "address low readback", 32'(rd), 32'hA5);
    hr(3'd4, rd); chk("R12", "length high readback", 32'(rd), 32'h3C);
    hr(3'd6, rd); chk("R12", "offset 6", 32'(rd), 32'd0);
    hr(3'd7, rd); chk("R12", "offset 7", 32'(rd), 32'd0);

    // R2 control written without execute
    hw(3'd3, 8'd4); hw(3'd4, 8'd0);
    hw(3'd0, 8'h02);
    any = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (rdy_pull || lock_pull) any = 1; end
    chk("R2", "no takeover without execute", 32'(any), 32'd0);
    hr(3'd5, rd); chk("R2", "not busy", 32'(rd), 32'd0);

    // R9 zero length
    hw(3'd3, 8'd0);
    hw(3'd0, 8'h01);
    any = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (rdy_pull || lock_pull || be_pull) any = 1; end
    chk("R9", "zero length never pulls", 32'(any), 32'd0);
    hr(3'd5, rd); chk("R9", "zero length done", 32'(rd), 32'h2);
    hw(3'd5, 8'h00);
    chk("R8", "writing 0 keeps done", 32'(irq), 32'd1);
    hw(3'd5, 8'h02);
    chk("R8", "writing 1 clears done", 32'(irq), 32'd0);

    // directed transfers
    run_xfer(16'h1000, 16'd1, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0);
    run_xfer(16'hFFFE, 16'd4, 1'b1, 1'b0, 3, 0, 1'b0, 1'b1);
    run_xfer(16'h2340, 16'd5, 1'b0, 1'b0, 4, 1, 1'b1, 1'b0);
    run_xfer(16'h0400, 16'd6, 1'b1, 1'b0, 5, 2, 1'b0, 1'b1);
    run_xfer(16'h8000, 16'd3, 1'b0, 1'b1, 4, 0, 1'b0, 1'b0);
    run_xfer(16'h8100, 16'd2, 1'b1, 1'b1, 0, 0, 1'b1, 1'b0);

    // random transfers
    for (int t = 0; t < 24; t++) begin
      run_xfer(16'($urandom), 16'(1 + ($urandom % 24)), 1'($urandom),
               ($urandom % 4) == 0, int'($urandom % 6), int'($urandom % 3),
               1'($urandom), 1'($urandom));
    end

    // R11 reset during a transfer
    hw(3'd1, 8'h00); hw(3'd2, 8'h20); hw(3'd3, 8'd30); hw(3'd4, 8'd0);
    hw(3'd0, 8'h03);
    for (int i = 0; i < 8 && !rdy_pull; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R11", "owning before reset", pins(), 32'b11111);
    rst_n = 1'b0;
    #1 chk("R11", "released at once", {pins()[31:1], irq}, 32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "idle after reset", {pins()[31:1], irq}, 32'd0);
    for (int s = 0; s < 6; s++) begin
      hr(3'(s), rd);
      chk("R11", "register cleared", 32'(rd), 32'd0);
    end

    summary();
    $finish;
  end
endmodule